// File: doc/BRIEF.md
# Prescaled Down-Counting Timer

This block is a 32-bit timer that counts down from a programmed value and signals expiry through a sticky status flag and a level interrupt. A processor drives it through a word-indexed register port that holds four registers. The first is a reload value. The second is a live count. The third is a control word holding an enable bit, an auto-reload bit and an 8-bit clock divider. The fourth is a status flag that software clears by writing a one.

Each decrement takes divider+1 clock cycles. When the count runs out, the flag is raised. The count is then either refilled from the reload register and counting goes on, or it stays at zero and the timer goes idle until software writes a new count. Any write that places a new count, and any enable edge, restarts the divider phase. This makes the time to the next expiry exactly count×(divider+1) cycles from that write.

Top module: `pdt_timer`

## Requirements
- R1: Word index 0 is the reload register, 1 the count, 2 the control word and 3 the status flag. Indices 4 to 7 read zero and writes to them change no register. Control keeps enable at bit 0, auto-reload at bit 1 and the divider P at bits 15:8. All other control bits read back as zero.
- R2: While enabled with a non-zero count, the count drops by one every P+1 clock cycles. A read of index 1 returns the current count.
- R3: The decrement that would take the count from 1 to 0 is an expiry. It sets the status flag. With auto-reload set, the count becomes the reload value. Otherwise it becomes 0 and counting stops.
- R4: A write to index 0 stores the value in both the reload register and the count. While enabled, it restarts the divider phase, so the next expiry comes value×(P+1) cycles after the write edge.
- R5: A write to index 1 replaces the count and, while enabled, restarts the divider phase. A count of zero neither counts nor expires.
- R6: A control write that turns enable from 0 to 1 while the count is zero and the new auto-reload bit is 1 first copies the reload value into the count.
- R7: While disabled, the count holds its value and a read of index 1 returns 0. A read of index 1 also returns 0 whenever the count is zero. After re-enabling, the held count reads back.
- R8: Writing 1 to bit 0 of index 3 clears the status flag, which reads at bit 0. The irq output equals the flag. An expiry in the same cycle as a clear leaves the flag set.
- R9: Synchronous reset clears reload, count, control, status and the divider phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one word per cycle |
| addr | input | 3 | Word index of the register access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt, equal to the status flag |

## Verification
On every cycle, the assertions check the following. An expiry raises the flag, and an expiry wins over a clear. A clear without an expiry drops the flag. After an expiry, the count is either refilled or left at zero, following the auto-reload bit. The count holds whenever no decrement and no write happen. Divider ticks never come in back-to-back cycles when P is non-zero. The exact expiry cycles after a restart, the enable-from-zero refill, the decode of unused indices and the zero readout while disabled can only be shown by the bench scenarios, which count edges from each write.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
    localparam int ADDR_W = 3;
    localparam int PRE_W  = 8;
    localparam int CTRL_W = 16;

    typedef enum logic [ADDR_W-1:0] {
        SEL_LOAD  = 3'd0,
        SEL_COUNT = 3'd1,
        SEL_CTRL  = 3'd2,
        SEL_STAT  = 3'd3
    } reg_sel_e;

    // Control word layout: bit 0 enable, bit 1 auto-reload, bits 15:8 divider.
    typedef struct packed {
        logic [PRE_W-1:0] divider;
        logic [5:0]       rsvd;
        logic             reload;
        logic             enable;
    } ctrl_t;

    function automatic ctrl_t word_to_ctrl(input logic [CTRL_W-1:0] w);
        ctrl_t c;
        c         = ctrl_t'(w);
        c.rsvd    = '0;
        return c;
    endfunction
endpackage

// File: rtl/pdt_prescaler.sv
module pdt_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] limit,
    output logic             tick
);
    logic [PRE_W-1:0] phase_q;

    assign tick = run && !restart && (phase_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            phase_q <= '0;
        end else if (phase_q >= limit) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // R2: with a non-zero divider, ticks are never in consecutive cycles
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick && limit != '0) |=> (!tick || $changed(limit)));
endmodule

// File: rtl/pdt_counter.sv
module pdt_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_count,
    input  logic [DATA_W-1:0] wr_val,
    input  logic              arm_reload,
    input  logic [DATA_W-1:0] load_val,
    input  logic              reload_en,
    input  logic              tick,
    output logic [DATA_W-1:0] count,
    output logic              expire
);
    logic [DATA_W-1:0] count_q;

    assign count  = count_q;
    assign expire = tick && (count_q == DATA_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (wr_count) begin
            count_q <= wr_val;
        end else if (arm_reload) begin
            count_q <= load_val;
        end else if (expire) begin
            count_q <= reload_en ? load_val : '0;
        end else if (tick && count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    // R3: one-shot expiry leaves the count at zero
    a_r3_stop_at_zero: assert property (@(posedge clk) disable iff (rst)
        (expire && !reload_en && !wr_count) |=> (count_q == '0));
    // R3: auto-reload expiry refills from the reload value
    a_r3_refill: assert property (@(posedge clk) disable iff (rst)
        (expire && reload_en && !wr_count) |=> (count_q == $past(load_val)));
    // R7: no tick and no write means the count holds
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_count && !arm_reload) |=> $stable(count_q));
endmodule

// File: rtl/pdt_status.sv
module pdt_status (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    logic flag_q;

    assign flag = flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (set) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

    // R8: an expiry always leaves the flag set, even against a clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        set |=> flag_q);
    // R8: a clear without an expiry drops the flag
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !flag_q);
endmodule

// File: rtl/pdt_timer.sv
module pdt_timer
    import pdt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic [DATA_W-1:0] load_q;
    ctrl_t             ctrl_q;
    ctrl_t             ctrl_new;
    logic [DATA_W-1:0] count;
    logic              wr_load, wr_cnt, wr_ctrl, wr_stat;
    logic              enable_rise, arm_reload, restart, run;
    logic              tick, expire, flag;

    assign wr_load  = wr_en && (reg_sel_e'(addr) == SEL_LOAD);
    assign wr_cnt   = wr_en && (reg_sel_e'(addr) == SEL_COUNT);
    assign wr_ctrl  = wr_en && (reg_sel_e'(addr) == SEL_CTRL);
    assign wr_stat  = wr_en && (reg_sel_e'(addr) == SEL_STAT);
    assign ctrl_new = word_to_ctrl(wdata[CTRL_W-1:0]);

    assign enable_rise = wr_ctrl && ctrl_new.enable && !ctrl_q.enable;
    assign arm_reload  = enable_rise && (count == '0) && ctrl_new.reload;
    assign restart     = enable_rise || (ctrl_q.enable && (wr_load || wr_cnt));
    assign run         = ctrl_q.enable && (count != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q <= '0;
            ctrl_q <= '0;
        end else begin
            if (wr_load) load_q <= wdata;
            if (wr_ctrl) ctrl_q <= ctrl_new;
        end
    end

    pdt_prescaler #(.PRE_W(PRE_W)) u_prescaler (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (restart),
        .limit   (ctrl_q.divider),
        .tick    (tick)
    );

    pdt_counter #(.DATA_W(DATA_W)) u_counter (
        .clk        (clk),
        .rst        (rst),
        .wr_count   (wr_load || wr_cnt),
        .wr_val     (wdata),
        .arm_reload (arm_reload),
        .load_val   (load_q),
        .reload_en  (ctrl_q.reload),
        .tick       (tick),
        .count      (count),
        .expire     (expire)
    );

    pdt_status u_status (
        .clk  (clk),
        .rst  (rst),
        .set  (expire),
        .clr  (wr_stat && wdata[0]),
        .flag (flag)
    );

    assign irq = flag;

    always_comb begin
        rdata = '0;
        case (reg_sel_e'(addr))
            SEL_LOAD:  rdata = load_q;
            SEL_COUNT: rdata = (ctrl_q.enable && count != '0) ? count : '0;
            SEL_CTRL:  rdata = DATA_W'(ctrl_q);
            SEL_STAT:  rdata = DATA_W'(flag);
            default:   rdata = '0;
        endcase
    end

    // R8: the interrupt is up in the cycle after any expiry
    a_r8_irq_on_expiry: assert property (@(posedge clk) disable iff (rst)
        expire |=> irq);
    // R1: writes to unused indices leave reload and control untouched
    a_r1_unused_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr[2]) |=> ($stable(load_q) && $stable(ctrl_q)));
endmodule

// File: tb/pdt_timer_tb.sv
module pdt_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [2:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pdt_timer #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    typedef struct packed {
        logic          rd;
        logic [2:0]    a;
        logic [DW-1:0] d;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd0, 32'h0000_1234, 4'd4},  // R4 load write
        '{1'b1, 3'd0, 32'h0000_1234, 4'd1},  // R1 load readback
        '{1'b1, 3'd1, 32'h0000_0000, 4'd7},  // R7 disabled reads zero
        '{1'b0, 3'd2, 32'h0000_0502, 4'd1},
        '{1'b1, 3'd2, 32'h0000_0502, 4'd1},  // R1 control fields
        '{1'b0, 3'd2, 32'hFFFF_FFFC, 4'd1},
        '{1'b1, 3'd2, 32'h0000_FF00, 4'd1},  // R1 other bits read zero
        '{1'b0, 3'd5, 32'h0000_DEAD, 4'd1},
        '{1'b1, 3'd5, 32'h0000_0000, 4'd1},  // R1 unused reads zero
        '{1'b1, 3'd0, 32'h0000_1234, 4'd1},  // R1 unused write ignored
        '{1'b0, 3'd3, 32'h0000_0001, 4'd8},
        '{1'b1, 3'd3, 32'h0000_0000, 4'd8},  // R8 status idle
        '{1'b0, 3'd2, 32'h0000_0000, 4'd1},
        '{1'b1, 3'd7, 32'h0000_0000, 4'd1}   // R1 top index reads zero
    };

    task automatic check(input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [2:0] a,
                            input logic [DW-1:0] exp);
        addr = a;
        #1;
        check(tag, rdata, exp);
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<20000", cycles);
            finish_run();
        end
    end

    initial begin
        edges(3);
        rst = 1'b0;
        // R9 reset state
        rd_check("R9 load", 3'd0, 0);
        rd_check("R9 count", 3'd1, 0);
        rd_check("R9 ctrl", 3'd2, 0);
        rd_check("R9 status", 3'd3, 0);
        check("R9 irq", DW'(irq), 0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].rd) begin
                rd_check($sformatf("R%0d table[%0d]", VECS[i].req, i),
                         VECS[i].a, VECS[i].d);
            end else begin
                wr(VECS[i].a, VECS[i].d);
            end
        end

        // R2 one-shot with divider 1: count 3 expires 6 edges after enable
        wr(3'd1, 3);
        wr(3'd2, 32'h0101);
        rd_check("R2 count after enable", 3'd1, 3);
        edges(2);
        rd_check("R2 count after one period", 3'd1, 2);
        edges(3);
        check("R2 irq before expiry", DW'(irq), 0);
        edges(1);
        check("R3 irq at expiry", DW'(irq), 1);
        rd_check("R3 one-shot count zero", 3'd1, 0);
        rd_check("R8 status reads one", 3'd3, 1);
        edges(4);
        check("R8 flag sticky", DW'(irq), 1);
        wr(3'd3, 1);
        check("R8 w1c clears", DW'(irq), 0);

        // R6 enable from zero with auto-reload
        wr(3'd2, 0);
        wr(3'd0, 4);
        rd_check("R7 disabled count reads zero", 3'd1, 0);
        wr(3'd1, 0);
        wr(3'd2, 32'h0003);
        rd_check("R6 count loaded on enable", 3'd1, 4);
        edges(3);
        check("R3 no irq before expiry", DW'(irq), 0);
        rd_check("R2 divider 0 count", 3'd1, 1);
        edges(1);
        check("R3 reload expiry irq", DW'(irq), 1);
        rd_check("R3 refilled count", 3'd1, 4);
        wr(3'd3, 1);
        check("R8 cleared while running", DW'(irq), 0);
        edges(2);
        check("R3 second period pending", DW'(irq), 0);
        edges(1);
        check("R3 second period expiry", DW'(irq), 1);

        // R4 load write restarts the divider phase
        wr(3'd2, 0);
        wr(3'd3, 1);
        wr(3'd0, 2);
        wr(3'd2, 32'h0301);
        edges(3);
        wr(3'd0, 2);
        rd_check("R4 count after load write", 3'd1, 2);
        edges(7);
        check("R4 no early expiry", DW'(irq), 0);
        edges(1);
        check("R4 expiry after restart", DW'(irq), 1);
        rd_check("R3 one-shot stops", 3'd1, 0);

        // R8 expiry and clear in the same cycle
        wr(3'd2, 0);
        wr(3'd3, 1);
        wr(3'd1, 1);
        wr(3'd2, 32'h0001);
        wr(3'd3, 1);
        check("R8 expiry wins over clear", DW'(irq), 1);

        // R5 zero count does not run; counter write restarts
        wr(3'd3, 1);
        wr(3'd1, 0);
        edges(10);
        check("R5 zero count no expiry", DW'(irq), 0);
        wr(3'd1, 2);
        rd_check("R5 counter write value", 3'd1, 2);
        edges(1);
        check("R5 not yet expired", DW'(irq), 0);
        edges(1);
        check("R5 expiry after counter write", DW'(irq), 1);

        // R7 disabled hold
        wr(3'd3, 1);
        wr(3'd2, 0);
        wr(3'd1, 5);
        edges(10);
        rd_check("R7 disabled reads zero", 3'd1, 0);
        check("R7 no irq while disabled", DW'(irq), 0);
        wr(3'd2, 32'h0001);
        rd_check("R7 held count after enable", 3'd1, 5);

        finish_run();
    end
endmodule